// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block is a serial slave for programming a bank of nine control registers over three wires: a data line, a shift clock and a load-enable line. Words are shifted in MSB first into a 24-bit shift register on rising edges of the shift clock while load enable is low. A low-to-high transition of load enable commits the shifted word. The low bits of the word select the target register, and the remaining upper bits become that register's new contents.

Register 0 holds the main divide value. It is selected by a single flag bit, so its 23-bit payload can be replaced in one write. Registers 1 to 8 take a 20-bit payload and are selected by a flag plus a 3-bit code. Every register is exposed in parallel. Each register has a one-cycle update strobe that tells downstream logic a new value has arrived. A chip-enable input forces the power-down report high, whatever the registers hold.

The three serial lines and chip enable are asynchronous to the system clock. Each passes through a two-stage synchronizer before any edge detection.

Top module: `sreg_loader`

## Requirements
- R1: After reset, register 0 and registers 1..8 read zero, all update strobes are low and `powered_down` is 1.
- R2: Each rising edge of `ser_clk` seen while `ser_le` is low shifts `ser_data` into bit 0 of the 24-bit shift register, so the word is sent MSB first. Only the last 24 bits sent before the load count.
- R3: A committed word whose bit 0 is 0 loads word bits 23:1 into register 0 (23 bits, `main_reg`).
- R4: A committed word whose bit 0 is 1 loads word bits 23:4 into register code+1, where code is word bits 3:1. Register k occupies `aux_regs[(k-1)*20 +: 20]`.
- R5: Each commit raises exactly the strobe bit of the written register (bit k for register k) for one cycle. No other register changes.
- R6: Rising edges of `ser_clk` while `ser_le` is high leave the shift register untouched.
- R7: A commit happens only on a low-to-high transition of `ser_le`. Holding it high or lowering it writes nothing.
- R8: `powered_down` is 1 whenever `chip_en` is low. Otherwise it equals bit 19 of register 1 (word bit 23 of a register-1 write).
- R9: Register contents and the strobe change on the third rising edge of `clk` after `ser_le` rises, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock |
| ser_le | input | 1 | Load enable; rising edge commits the word |
| chip_en | input | 1 | Chip enable; low forces power-down report |
| main_reg | output | 23 | Register 0 contents |
| aux_regs | output | 160 | Registers 1..8, 20 bits each, register 1 in the low bits |
| upd_stb | output | 9 | One-cycle update strobe per register |
| powered_down | output | 1 | Power-down report |

## Verification
A shift register that slips by one bit shows on the next commit as a shifted payload and, often, a wrong target strobe, three cycles after the load-enable edge. A bad decode writes the wrong register or raises two strobes in that same cycle. A missing guard on shifting while load enable is high only shows when a word is re-committed without new shifting. The reference model compares every output on every clock, so any divergence is reported in the cycle it first reaches the ports.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  // Synchronized view of the serial lines, in the order they are packed.
  typedef struct packed {
    logic ce;
    logic le;
    logic sck;
    logic sdi;
  } ser_lines_t;

  localparam int LINES_W = $bits(ser_lines_t);
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              le_s,
  input  logic              sdi_s,
  output logic [WORD_W-1:0] word,
  output logic              load_go
);
  logic sck_d, le_d;
  logic sck_rise;

  assign sck_rise = sck_s & ~sck_d;
  assign load_go  = le_s & ~le_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      le_d  <= 1'b0;
      word  <= '0;
    end else begin
      sck_d <= sck_s;
      le_d  <= le_s;
      if (sck_rise && !le_s) word <= {word[WORD_W-2:0], sdi_s};
    end
  end

  // R6: no shifting while load enable is high
  a_r6_frozen_le_high: assert property (@(posedge clk) disable iff (rst)
    le_s |=> $stable(word));

  // R2: MSB-first shift, new bit enters at the bottom
  a_r2_shift_in_low: assert property (@(posedge clk) disable iff (rst)
    (sck_rise && !le_s) |=> (word[0] == $past(sdi_s)) &&
                             (word[WORD_W-1:1] == $past(word[WORD_W-2:0])));
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile #(
  parameter int WORD_W   = 24,
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 9,
  localparam int WIDE_W   = WORD_W - 1,
  localparam int NARROW_W = WORD_W - 1 - ADDR_W,
  localparam int AUX_N    = NUM_REGS - 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [WORD_W-1:0]         word,
  input  logic                      load_go,
  output logic [WIDE_W-1:0]         main_q,
  output logic [AUX_N*NARROW_W-1:0] aux_q,
  output logic [NUM_REGS-1:0]       stb
);
  logic                is_main;
  logic [ADDR_W-1:0]   code;
  logic [NUM_REGS-1:0] hit;

  assign is_main = ~word[0];
  assign code    = word[ADDR_W:1];
  assign hit[0]  = load_go & is_main;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= '0;
      stb    <= '0;
    end else begin
      stb <= hit;
      if (hit[0]) main_q <= word[WORD_W-1 -: WIDE_W];
    end
  end

  generate
    for (genvar i = 1; i < NUM_REGS; i++) begin : g_aux
      assign hit[i] = load_go & ~is_main & (code == ADDR_W'(i-1));
      always_ff @(posedge clk) begin
        if (rst) aux_q[(i-1)*NARROW_W +: NARROW_W] <= '0;
        else if (hit[i]) aux_q[(i-1)*NARROW_W +: NARROW_W] <= word[WORD_W-1 -: NARROW_W];
      end
    end
  endgenerate

  // R5: at most one strobe per cycle
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));

  // R5: a strobe only follows a commit request
  a_r5_strobe_needs_load: assert property (@(posedge clk) disable iff (rst)
    (|stb) |-> $past(load_go));

  // R7: without a commit request nothing is written
  a_r7_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !load_go |=> ($stable(main_q) && $stable(aux_q)));
endmodule

// File: rtl/sreg_loader.sv
module sreg_loader #(
  parameter int WORD_W      = 24,
  parameter int ADDR_W      = 3,
  parameter int NUM_REGS    = 9,
  parameter int SYNC_STAGES = 2,
  parameter int PD_BIT      = 19,
  localparam int WIDE_W   = WORD_W - 1,
  localparam int NARROW_W = WORD_W - 1 - ADDR_W,
  localparam int AUX_W    = (NUM_REGS - 1) * NARROW_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_data,
  input  logic                ser_clk,
  input  logic                ser_le,
  input  logic                chip_en,
  output logic [WIDE_W-1:0]   main_reg,
  output logic [AUX_W-1:0]    aux_regs,
  output logic [NUM_REGS-1:0] upd_stb,
  output logic                powered_down
);
  import sreg_pkg::*;

  ser_lines_t            raw, synced;
  logic [LINES_W-1:0]    synced_bits;
  logic [WORD_W-1:0]     word;
  logic                  load_go;

  assign raw = '{ce: chip_en, le: ser_le, sck: ser_clk, sdi: ser_data};

  sreg_sync #(.W(LINES_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_in(raw), .q(synced_bits)
  );
  assign synced = synced_bits;

  sreg_shifter #(.WORD_W(WORD_W)) shift_i (
    .clk(clk), .rst(rst),
    .sck_s(synced.sck), .le_s(synced.le), .sdi_s(synced.sdi),
    .word(word), .load_go(load_go)
  );

  sreg_regfile #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) rf_i (
    .clk(clk), .rst(rst), .word(word), .load_go(load_go),
    .main_q(main_reg), .aux_q(aux_regs), .stb(upd_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) powered_down <= 1'b1;
    else     powered_down <= ~synced.ce | aux_regs[PD_BIT];
  end

  // R8: chip enable low forces the power-down report
  a_r8_ce_forces_pd: assert property (@(posedge clk) disable iff (rst)
    !synced.ce |=> powered_down);
endmodule

// File: tb/sreg_loader_tb.sv
module sreg_loader_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_le = 1'b0, chip_en = 1'b0;
  logic [22:0]  main_reg;
  logic [159:0] aux_regs;
  logic [8:0]   upd_stb;
  logic         powered_down;

  always #2.5 clk = ~clk;

  sreg_loader dut_i (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_le(ser_le), .chip_en(chip_en), .main_reg(main_reg),
    .aux_regs(aux_regs), .upd_stb(upd_stb), .powered_down(powered_down)
  );

  int compared = 0, mismatched = 0;
  string phase = "R1";

  // Behavioural reference: input history, shift word, register bank
  logic [2:0]   hd, hc, hl, he;
  logic [23:0]  m_sh;
  logic [22:0]  m_main;
  logic [159:0] m_aux;
  logic [8:0]   m_stb;
  logic         m_pd;

  always @(posedge clk) begin
    if (rst) begin
      hd = 0; hc = 0; hl = 0; he = 0;
      m_sh = 0; m_main = 0; m_aux = 0; m_stb = 0; m_pd = 1;
    end else begin
      logic [23:0] old_sh;
      old_sh = m_sh;
      m_pd  = !he[1] || m_aux[19];
      m_stb = 0;
      if (hc[1] && !hc[2] && !hl[1]) m_sh = {m_sh[22:0], hd[1]};
      if (hl[1] && !hl[2]) begin
        if (!old_sh[0]) begin
          m_main = old_sh[23:1];
          m_stb[0] = 1;
        end else begin
          int idx;
          idx = int'(old_sh[3:1]) + 1;
          m_aux[(idx-1)*20 +: 20] = old_sh[23:4];
          m_stb[idx] = 1;
        end
      end
      hd = {hd[1:0], ser_data};
      hc = {hc[1:0], ser_clk};
      hl = {hl[1:0], ser_le};
      he = {he[1:0], chip_en};
    end
  end

  task automatic check(string tag, logic [159:0] act, logic [159:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("R3 main", 160'(main_reg), 160'(m_main));
      check("R4 aux", aux_regs, m_aux);
      check("R5 strobe", 160'(upd_stb), 160'(m_stb));
      check("R8 pd", 160'(powered_down), 160'(m_pd));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(logic b);
    ser_data = b; cyc(4);
    ser_clk = 1; cyc(4);
    ser_clk = 0; cyc(2);
  endtask

  // Raise load enable and check the R9 latency and R5 strobe directly
  task automatic commit(int tgt);
    ser_le = 1;
    cyc(2);
    check("R9 early", 160'(upd_stb), 160'(0));
    cyc(1);
    check("R9 strobe", 160'(upd_stb), 160'(9'(1) << tgt));
    cyc(1);
    check("R5 one cycle", 160'(upd_stb), 160'(0));
    cyc(2);
    ser_le = 0;
    cyc(4);
  endtask

  task automatic send_word(logic [23:0] w, int tgt);
    for (int i = 23; i >= 0; i--) shift_bit(w[i]);
    commit(tgt);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    mismatched++;
    $display("FAIL watchdog [%s] actual=timeout expected=done", phase);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cyc(5);
    rst = 0;
    @(negedge clk);
    phase = "R1";
    check("R1 main", 160'(main_reg), 160'(0));
    check("R1 aux", aux_regs, 160'(0));
    check("R1 strobe", 160'(upd_stb), 160'(0));
    check("R1 pd", 160'(powered_down), 160'(1));
    chip_en = 1;
    cyc(4);
    check("R8 enabled", 160'(powered_down), 160'(0));

    phase = "R3";
    send_word({23'h5A3C96, 1'b0}, 0);
    check("R3 payload", 160'(main_reg), 160'(23'h5A3C96));

    phase = "R4";
    for (int k = 1; k <= 8; k++) begin
      logic [19:0] p;
      p = 20'(k * 20'h11111) ^ 20'h0F0F0;
      p[19] = 1'b0;
      send_word({p, 3'(k-1), 1'b1}, k);
      check("R4 payload", 160'(aux_regs[(k-1)*20 +: 20]), 160'(p));
    end
    check("R5 main kept", 160'(main_reg), 160'(23'h5A3C96));

    // R6/R7: shifting with load enable high, then falling edge, writes nothing
    phase = "R6";
    begin
      logic [159:0] snap_aux;
      snap_aux = aux_regs;
      ser_le = 1; cyc(4);
      for (int i = 0; i < 24; i++) shift_bit(i[0]);
      cyc(4);
      check("R7 held high", aux_regs, snap_aux);
      ser_le = 0; cyc(6);
      check("R7 falling", aux_regs, snap_aux);
      commit(8);
      check("R6 word kept", aux_regs, snap_aux);
    end

    // R2: extra leading bits are pushed out; last 24 count
    phase = "R2";
    for (int i = 0; i < 7; i++) shift_bit(1'b1);
    send_word({20'hC0DE5, 3'd4, 1'b1}, 5);
    check("R2 last 24", 160'(aux_regs[4*20 +: 20]), 160'(20'hC0DE5));
    send_word({23'h000001, 1'b0}, 0);
    check("R2 lsb", 160'(main_reg), 160'(1));

    // R8: register 1 bit 19 and chip enable
    phase = "R8";
    send_word({20'h80001, 3'd0, 1'b1}, 1);
    check("R8 pd bit", 160'(powered_down), 160'(1));
    send_word({20'h00001, 3'd0, 1'b1}, 1);
    check("R8 pd clear", 160'(powered_down), 160'(0));
    chip_en = 0; cyc(4);
    check("R8 ce low", 160'(powered_down), 160'(1));
    chip_en = 1; cyc(4);
    check("R8 ce high", 160'(powered_down), 160'(0));

    cyc(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule